// File: doc/BRIEF.md
# Register Preload and Configuration Security Controller

This block is the test and protection logic around a programmable device's configuration store and its bank of output flip-flops. In normal running, the output flip-flops take their next value from the array logic each clock, or all ones when the synchronous preset term is high. A test host can also force any pattern into every flip-flop straight from the pin values. This preload lets a state machine be started in an arbitrary state, including states its own logic could never reach, so that recovery from them can be observed.

The configuration store holds the cell pattern as words. A host writes words, reads them back, and can clear the whole store with an erase. A one-way security flag hides the pattern. Once the flag is set, every readback returns unconnected cells (all ones) and every preload is silently ignored. The only way to drop the flag is a full-pattern erase. The erase walks the store one word per cycle with a busy flag raised, and clears the flag together with the last word.

Commands arrive one per cycle on a valid strobe with an opcode, a word address and write data.

Top module: `cfg_guard_ctrl`

## Requirements
- R1: After reset the output flip-flops hold 0, busy and the security flag are low, and every store cell reads back as 1 (unprogrammed).
- R2: A program command (opcode 1) writes the data word at the address. A read command (opcode 2) raises rd_valid for one cycle in the next cycle, with the stored word on rd_data.
- R3: An accepted preload command (opcode 3) with the security flag low loads every output flip-flop from pin_in at that clock edge, whatever the value. The flip-flops return to following reg_d on the edge after.
- R4: When a preload and sync_preset fall in the same cycle, the preload wins and the flip-flops take pin_in.
- R5: Without preload, each clock loads all ones into the flip-flops if sync_preset is high, and reg_d otherwise.
- R6: A secure command (opcode 4) raises the security flag from the next cycle on. The flag then stays high until an erase finishes.
- R7: While the security flag is high, a preload has no effect: the flip-flops keep following reg_d or sync_preset.
- R8: While the security flag is high, a read returns all ones on rd_data, whatever the stored word.
- R9: An erase command (opcode 5) holds busy high for exactly DEPTH cycles. After that, every store word reads all ones.
- R10: The security flag drops in the same cycle as busy. A read issued in the very first cycle after busy falls is accepted and returns all ones.
- R11: A command presented while busy is high, and any command with opcode 6 or 7, is rejected. cmd_reject goes high in the next cycle, and the command has no effect (for a read, rd_valid stays low). Opcode 0 is an accepted no-operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Opcode: 0 nop, 1 program, 2 read, 3 preload, 4 secure, 5 erase |
| cmd_addr | input | ADDR_W (4) | Store word address |
| cmd_wdata | input | WORD_W (8) | Word to program |
| pin_in | input | NREG (8) | Pin values used as preload source |
| reg_d | input | NREG (8) | Next state from the array logic |
| sync_preset | input | 1 | Synchronous preset term, sets all flip-flops |
| reg_q | output | NREG (8) | Output flip-flop state |
| rd_valid | output | 1 | Readback word valid |
| rd_data | output | WORD_W (8) | Readback word |
| busy | output | 1 | Erase in progress |
| secured | output | 1 | Security flag |
| cmd_reject | output | 1 | Previous-cycle command was rejected |

## Verification
Preload and synchronous preset can land on the same clock edge. The bench raises sync_preset and issues a preload in that same cycle, with a pin pattern unlike all ones. It then requires the pin pattern in the flip-flops, followed by all ones one edge later. A second overlap occurs at the end of an erase, where the security flag and busy fall together. Here the bench issues a read in the first cycle after busy drops and requires an accepted, unmasked all-ones word with no rejection.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_NOP     = 3'd0,
      OP_PROG    = 3'd1,
      OP_READ    = 3'd2,
      OP_PRELOAD = 3'd3,
      OP_SECURE  = 3'd4,
      OP_ERASE   = 3'd5
   } guard_op_e;
endpackage

// File: rtl/cfg_guard_decode.sv
module cfg_guard_decode
   import cfg_guard_pkg::*;
(
   input  logic            cmd_valid,
   input  logic [OP_W-1:0] cmd_op,
   input  logic            busy,
   input  logic            secured,
   output logic            do_prog,
   output logic            do_read,
   output logic            do_preload,
   output logic            do_secure,
   output logic            do_erase,
   output logic            do_reject
);
   always_comb begin
      do_prog    = 1'b0;
      do_read    = 1'b0;
      do_preload = 1'b0;
      do_secure  = 1'b0;
      do_erase   = 1'b0;
      do_reject  = 1'b0;
      if (cmd_valid) begin
         if (busy) begin
            do_reject = 1'b1;
         end else begin
            case (cmd_op)
               OP_NOP:     ;
               OP_PROG:    do_prog    = 1'b1;
               OP_READ:    do_read    = 1'b1;
               OP_PRELOAD: do_preload = !secured;  // silently dropped when secured
               OP_SECURE:  do_secure  = 1'b1;
               OP_ERASE:   do_erase   = 1'b1;
               default:    do_reject  = 1'b1;
            endcase
         end
      end
   end
endmodule

// File: rtl/cfg_guard_store.sv
module cfg_guard_store #(
   parameter int WORD_W = 8,
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              do_prog,
   input  logic              do_read,
   input  logic              do_secure,
   input  logic              do_erase,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   output logic              busy,
   output logic              secured,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data
);
   localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(DEPTH - 1);
   localparam logic [WORD_W-1:0] BLANK     = {WORD_W{1'b1}};

   logic [WORD_W-1:0] cells [DEPTH];
   logic [ADDR_W-1:0] wipe_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < DEPTH; w++) cells[w] <= BLANK;
         busy     <= 1'b0;
         secured  <= 1'b0;
         wipe_ptr <= '0;
         rd_valid <= 1'b0;
         rd_data  <= BLANK;
      end else begin
         rd_valid <= do_read;
         if (do_read) rd_data <= secured ? BLANK : cells[addr];
         if (do_prog) cells[addr] <= wdata;
         if (do_secure) secured <= 1'b1;
         if (do_erase) begin
            busy     <= 1'b1;
            wipe_ptr <= '0;
         end else if (busy) begin
            cells[wipe_ptr] <= BLANK;
            if (wipe_ptr == LAST_WORD) begin
               busy    <= 1'b0;
               secured <= 1'b0;
            end else begin
               wipe_ptr <= wipe_ptr + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/cfg_guard_outregs.sv
module cfg_guard_outregs #(
   parameter int NREG = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_pins,
   input  logic            sync_preset,
   input  logic [NREG-1:0] pin_in,
   input  logic [NREG-1:0] reg_d,
   output logic [NREG-1:0] reg_q
);
   for (genvar i = 0; i < NREG; i++) begin : g_cell
      logic cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cell_q <= 1'b0;
         else if (load_pins)   cell_q <= pin_in[i];
         else if (sync_preset) cell_q <= 1'b1;
         else                  cell_q <= reg_d[i];
      end
      assign reg_q[i] = cell_q;
   end
endmodule

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl
   import cfg_guard_pkg::*;
#(
   parameter int  NREG   = 8,
   parameter int  WORD_W = 8,
   parameter int  DEPTH  = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [OP_W-1:0]   cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [WORD_W-1:0] cmd_wdata,
   input  logic [NREG-1:0]   pin_in,
   input  logic [NREG-1:0]   reg_d,
   input  logic              sync_preset,
   output logic [NREG-1:0]   reg_q,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data,
   output logic              busy,
   output logic              secured,
   output logic              cmd_reject
);
   if (DEPTH < 2 || (1 << ADDR_W) != DEPTH) begin : g_bad_depth
      $error("cfg_guard_ctrl: DEPTH must be a power of two, at least 2");
   end
   if (NREG < 1 || WORD_W < 1) begin : g_bad_width
      $error("cfg_guard_ctrl: NREG and WORD_W must be positive");
   end

   logic do_prog, do_read, do_preload, do_secure, do_erase, do_reject;

   cfg_guard_decode u_decode (
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .busy      (busy),
      .secured   (secured),
      .do_prog   (do_prog),
      .do_read   (do_read),
      .do_preload(do_preload),
      .do_secure (do_secure),
      .do_erase  (do_erase),
      .do_reject (do_reject)
   );

   cfg_guard_store #(.WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_prog  (do_prog),
      .do_read  (do_read),
      .do_secure(do_secure),
      .do_erase (do_erase),
      .addr     (cmd_addr),
      .wdata    (cmd_wdata),
      .busy     (busy),
      .secured  (secured),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   cfg_guard_outregs #(.NREG(NREG)) u_outregs (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_pins  (do_preload),
      .sync_preset(sync_preset),
      .pin_in     (pin_in),
      .reg_d      (reg_d),
      .reg_q      (reg_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmd_reject <= 1'b0;
      else        cmd_reject <= do_reject;
   end
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk
   import cfg_guard_pkg::*;
#(
   parameter int NREG   = 8,
   parameter int WORD_W = 8,
   parameter int DEPTH  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [OP_W-1:0]   cmd_op,
   input logic [NREG-1:0]   pin_in,
   input logic [NREG-1:0]   reg_d,
   input logic              sync_preset,
   input logic [NREG-1:0]   reg_q,
   input logic              rd_valid,
   input logic [WORD_W-1:0] rd_data,
   input logic              busy,
   input logic              secured,
   input logic              cmd_reject
);
   logic pl_req;
   assign pl_req = cmd_valid && (cmd_op == OP_PRELOAD) && !busy;

   int busy_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cnt <= 0;
      else if (busy) busy_cnt <= busy_cnt + 1;
      else           busy_cnt <= 0;
   end

   a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == OP_READ && !busy |=> rd_valid);

   a_r3_preload_loads: assert property (@(posedge clk) disable iff (!rst_n)
      pl_req && !secured |=> reg_q == $past(pin_in));

   a_r5_preset_sets: assert property (@(posedge clk) disable iff (!rst_n)
      sync_preset && !(pl_req && !secured) |=> reg_q == {NREG{1'b1}});

   a_r7_secure_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      pl_req && secured && !sync_preset |=> reg_q == $past(reg_d));

   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(secured) |-> $fell(busy));

   a_r8_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && $past(secured) |-> rd_data == {WORD_W{1'b1}});

   a_r9_erase_length: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> busy_cnt == DEPTH);

   a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !secured);

   a_r11_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && busy |=> cmd_reject && !rd_valid);
endmodule

bind cfg_guard_ctrl cfg_guard_chk #(.NREG(NREG), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .pin_in     (pin_in),
   .reg_d      (reg_d),
   .sync_preset(sync_preset),
   .reg_q      (reg_q),
   .rd_valid   (rd_valid),
   .rd_data    (rd_data),
   .busy       (busy),
   .secured    (secured),
   .cmd_reject (cmd_reject)
);

// File: tb/cfg_guard_ctrl_bench.sv
module cfg_guard_ctrl_bench;
   localparam int NREG = 8, WORD_W = 8, DEPTH = 16, ADDR_W = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [WORD_W-1:0] cmd_wdata = '0;
   logic [NREG-1:0] pin_in = '0, reg_d = '0;
   logic sync_preset = 1'b0;
   logic [NREG-1:0] reg_q;
   logic rd_valid, busy, secured, cmd_reject;
   logic [WORD_W-1:0] rd_data;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cfg_guard_ctrl #(.NREG(NREG), .WORD_W(WORD_W), .DEPTH(DEPTH)) u_cfg_guard_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .pin_in(pin_in), .reg_d(reg_d),
      .sync_preset(sync_preset), .reg_q(reg_q), .rd_valid(rd_valid), .rd_data(rd_data),
      .busy(busy), .secured(secured), .cmd_reject(cmd_reject)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the next negedge with results visible
   task automatic do_cmd(input logic [2:0] op, input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = '0;
   endtask

   task automatic t_reset();
      check("R1 reg_q", reg_q, 0);
      check("R1 busy", busy, 0);
      check("R1 secured", secured, 0);
      do_cmd(3'd2, 4'd3, '0);
      check("R1 blank read", {rd_valid, rd_data}, {1'b1, 8'hFF});
   endtask

   task automatic t_program_read();
      do_cmd(3'd1, 4'd5, 8'hA5);
      do_cmd(3'd1, 4'd0, 8'h3C);
      do_cmd(3'd2, 4'd5, '0);
      check("R2 read addr5", {rd_valid, rd_data}, {1'b1, 8'hA5});
      do_cmd(3'd2, 4'd0, '0);
      check("R2 read addr0", {rd_valid, rd_data}, {1'b1, 8'h3C});
      @(negedge clk);
      check("R2 valid one cycle", rd_valid, 0);
   endtask

   task automatic t_run();
      reg_d = 8'h5A; sync_preset = 1'b0;
      @(negedge clk);
      check("R5 follows reg_d", reg_q, 8'h5A);
      sync_preset = 1'b1;
      @(negedge clk);
      check("R5 preset", reg_q, 8'hFF);
      sync_preset = 1'b0;
   endtask

   task automatic t_preload();
      reg_d = 8'h0F; pin_in = 8'hC3;
      do_cmd(3'd3, '0, '0);
      check("R3 preload", reg_q, 8'hC3);
      @(negedge clk);
      check("R3 back to reg_d", reg_q, 8'h0F);
      pin_in = 8'h81;
      do_cmd(3'd3, '0, '0);
      check("R3 unreachable state", reg_q, 8'h81);
   endtask

   task automatic t_collide();
      reg_d = 8'h00; pin_in = 8'h24; sync_preset = 1'b1;
      do_cmd(3'd3, '0, '0);
      check("R4 preload over preset", reg_q, 8'h24);
      @(negedge clk);
      check("R4 preset after", reg_q, 8'hFF);
      sync_preset = 1'b0;
   endtask

   task automatic t_bad_op();
      do_cmd(3'd7, 4'd1, 8'h00);
      check("R11 undefined op", cmd_reject, 1);
      do_cmd(3'd0, 4'd1, 8'h00);
      check("R11 nop accepted", cmd_reject, 0);
   endtask

   task automatic t_secure();
      do_cmd(3'd4, '0, '0);
      check("R6 flag set", secured, 1);
      do_cmd(3'd2, 4'd5, '0);
      check("R8 masked read", {rd_valid, rd_data}, {1'b1, 8'hFF});
      reg_d = 8'h11; pin_in = 8'h66;
      do_cmd(3'd3, '0, '0);
      check("R7 preload ignored", reg_q, 8'h11);
      repeat (3) @(negedge clk);
      check("R6 flag sticky", secured, 1);
   endtask

   task automatic t_erase();
      int cnt = 0;
      int guard = 0;
      do_cmd(3'd5, '0, '0);
      if (busy) cnt++;
      do_cmd(3'd2, 4'd5, '0);
      if (busy) cnt++;
      check("R11 busy reject", {cmd_reject, rd_valid}, {1'b1, 1'b0});
      while (busy && guard < 100) begin
         @(negedge clk);
         guard++;
         if (busy) cnt++;
      end
      check("R9 busy length", cnt, DEPTH);
      check("R10 flag cleared", secured, 0);
      do_cmd(3'd2, 4'd5, '0);
      check("R10 immediate read", {cmd_reject, rd_valid, rd_data}, {1'b0, 1'b1, 8'hFF});
      do_cmd(3'd2, 4'd0, '0);
      check("R9 word0 erased", rd_data, 8'hFF);
      reg_d = 8'h00; pin_in = 8'h5C;
      do_cmd(3'd3, '0, '0);
      check("R3 preload after erase", reg_q, 8'h5C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_program_read();
      t_run();
      t_preload();
      t_collide();
      t_bad_op();
      t_secure();
      t_erase();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule